// File: doc/BRIEF.md
# NAND Sector Single-Bit ECC Engine

This block builds a Hamming-style parity signature over one NAND sector while the bytes stream through it, one byte per accepted cycle. Every data bit has a 12-bit bit address, made of the byte index times eight plus the bit position. For each address bit the engine keeps two parities: one over the bits whose address bit is 0 and one over the bits whose address bit is 1. The 24 parities are packed into a 3-byte code and inverted. An erased sector that reads as all ones therefore yields an all-ones code.

On a read, the code that was kept in the spare area is presented on `stored_code` together with the last byte of the sector. The engine XORs it with the freshly computed code and sorts the result into one of four classes. It can be clean, or a correctable single data-bit error with its byte and bit. It can be an error in the stored code alone, or uncorrectable. Patching the sector buffer and driving the NAND bus are left to the surrounding logic.

Sequencing uses a three-state machine. IDLE waits for a start and ignores bytes. FILL counts accepted bytes. DONE holds for one cycle after the final byte and raises the done pulse. The transitions are start (IDLE, FILL or DONE to FILL), last-byte (any state to DONE), report-end (DONE to IDLE with no start) and hold (FILL stays FILL).

Top module: `nand_hamm_ecc`

## Requirements
- R1: While reset is asserted and after its release, `result_done` is 0 and `calc_code`, `ecc_status`, `err_byte` and `err_mask` are all 0.
- R2: For a data bit at address A = 8*byte + bit, code bit k (k < 12) is the XOR of all bits whose A[k] is 0. Code bit 12+k is the XOR of all bits whose A[k] is 1. The 24-bit result is inverted and is presented with code byte 0 on bits 7:0, byte 1 on bits 15:8 and byte 2 on bits 23:16.
- R3: A sector of all 0xFF bytes yields `calc_code` 24'hFFFFFF. With `stored_code` 24'hFFFFFF, such a sector reports status 0 (clean).
- R4: Results update, and `result_done` is 1 for exactly one cycle, in the cycle after the last sector byte is accepted. Between results every output holds its value.
- R5: `sec_start` discards any partial sector. When `byte_valid` is also high in that cycle, the byte is taken as byte 0 of a new sector.
- R6: Bytes with `byte_valid` high are ignored when no sector is open (before any start, or after a sector completes). Cycles with `byte_valid` low inside a sector are skipped without effect.
- R7: The syndrome S is `calc_code` XOR the `stored_code` sampled with the last byte. S = 0 gives status 0, `err_byte` 0 and `err_mask` 0.
- R8: If S[11:0] XOR S[23:12] is 12'hFFF and S[23:15] < SECTOR_BYTES, status is 1 (corrected). `err_byte` is then S[23:15] and `err_mask` is one-hot at bit S[14:12].
- R9: A syndrome that passes the complement test of R8 but has S[23:15] >= SECTOR_BYTES gives status 3 (uncorrectable) with `err_mask` 0.
- R10: A non-zero S with exactly one bit set gives status 2 (error in the stored code only), with `err_byte` 0 and `err_mask` 0.
- R11: Any other non-zero S, including the one left by two flipped data bits, gives status 3 with `err_byte` 0 and `err_mask` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sec_start | input | 1 | Begins a new sector and clears the parities |
| byte_valid | input | 1 | `byte_in` carries a sector byte this cycle |
| byte_in | input | 8 | Sector data byte |
| stored_code | input | 24 | Code read from the spare area, sampled with the last byte |
| calc_code | output | 24 | Inverted packed parity code of the last sector |
| ecc_status | output | 2 | 0 clean, 1 corrected, 2 code-only error, 3 uncorrectable |
| err_byte | output | 9 | Byte index to repair when status is 1 |
| err_mask | output | 8 | One-hot bit to flip in that byte when status is 1 |
| result_done | output | 1 | One-cycle pulse when the outputs carry a fresh result |

## Verification
The clocked checks assume that `stored_code` is stable across the cycle in which the final byte is accepted. They also assume that reset is applied before the first sector. The stimulus drives every input on the falling clock edge and holds the stored code through each whole sector. Starts are applied only as single-cycle strobes on a byte, including the deliberate mid-sector restart. Error cases are built by flipping chosen bits of the data or of a code worked out from the parity definition. With a second instance sized at 256 bytes, crafted syndromes can point past the end of the sector.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
    localparam int BIT_W  = 3;                 // bit position within a byte
    localparam int LINE_W = 9;                 // byte index field of the code
    localparam int HALF_W = LINE_W + BIT_W;    // one parity half
    localparam int CODE_W = 2 * HALF_W;        // full packed code
    localparam int DATA_W = 1 << BIT_W;

    typedef enum logic [1:0] {
        ST_CLEAN = 2'd0,
        ST_FIXED = 2'd1,
        ST_CODE  = 2'd2,
        ST_FATAL = 2'd3
    } ecc_status_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_FILL = 2'd1,
        S_DONE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/ecc_parity_acc.sv
module ecc_parity_acc
    import nand_ecc_pkg::*;
#(
    parameter int LW = LINE_W,
    parameter int BW = BIT_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     take,
    input  logic [LW-1:0]            line_idx,
    input  logic [(1<<BW)-1:0]       din,
    output logic [2*(LW+BW)-1:0]     par_now
);
    localparam int DW = 1 << BW;
    localparam int AW = LW + BW;

    function automatic logic [DW-1:0] lane_sel(input int k);
        logic [DW-1:0] m;
        for (int j = 0; j < DW; j++) begin
            m[j] = ((j >> k) & 1) == 1;
        end
        return m;
    endfunction

    logic [BW-1:0]   col_hi, col_lo;
    logic [LW-1:0]   row_hi, row_lo;
    logic            row_par;
    logic [2*AW-1:0] contrib, base, acc_q;

    assign row_par = ^din;

    generate
        for (genvar k = 0; k < BW; k++) begin : g_col
            assign col_hi[k] = ^(din &  lane_sel(k));
            assign col_lo[k] = ^(din & ~lane_sel(k));
        end
        for (genvar k = 0; k < LW; k++) begin : g_row
            assign row_hi[k] = row_par &  line_idx[k];
            assign row_lo[k] = row_par & ~line_idx[k];
        end
    endgenerate

    assign contrib = take  ? {row_hi, col_hi, row_lo, col_lo} : '0;
    assign base    = clear ? '0 : acc_q;
    assign par_now = base ^ contrib;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= par_now;
    end
endmodule

// File: rtl/ecc_syndrome_classify.sv
module ecc_syndrome_classify
    import nand_ecc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic [CODE_W-1:0] calc_code,
    input  logic [CODE_W-1:0] stored_code,
    output ecc_status_e       status,
    output logic [LINE_W-1:0] byte_idx,
    output logic [DATA_W-1:0] bit_mask
);
    logic [CODE_W-1:0] syn;
    logic [HALF_W-1:0] fold;
    logic [LINE_W-1:0] pos;
    logic [BIT_W-1:0]  bitsel;
    logic              single;

    always_comb begin
        syn      = calc_code ^ stored_code;
        fold     = syn[HALF_W-1:0] ^ syn[CODE_W-1:HALF_W];
        pos      = syn[CODE_W-1:HALF_W+BIT_W];
        bitsel   = syn[HALF_W+BIT_W-1:HALF_W];
        single   = (syn & (syn - 1'b1)) == '0;
        status   = ST_CLEAN;
        byte_idx = '0;
        bit_mask = '0;
        if (syn != '0) begin
            if (fold == '1) begin
                if (int'(pos) < SECTOR_BYTES) begin
                    status   = ST_FIXED;
                    byte_idx = pos;
                    bit_mask = DATA_W'(1) << bitsel;
                end else begin
                    status = ST_FATAL;
                end
            end else if (single) begin
                status = ST_CODE;
            end else begin
                status = ST_FATAL;
            end
        end
    end
endmodule

// File: rtl/nand_hamm_ecc.sv
module nand_hamm_ecc
    import nand_ecc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sec_start,
    input  logic        byte_valid,
    input  logic [7:0]  byte_in,
    input  logic [23:0] stored_code,
    output logic [23:0] calc_code,
    output logic [1:0]  ecc_status,
    output logic [8:0]  err_byte,
    output logic [7:0]  err_mask,
    output logic        result_done
);
    localparam logic [LINE_W-1:0] LAST_IDX = LINE_W'(SECTOR_BYTES - 1);

    seq_state_e        state_q, state_d;
    logic [LINE_W-1:0] cnt_q, line_idx;
    logic              accept, last_take;
    logic [CODE_W-1:0] par_now, code_now;
    ecc_status_e       cls_status;
    logic [LINE_W-1:0] cls_byte;
    logic [DATA_W-1:0] cls_mask;

    assign accept    = byte_valid && (sec_start || state_q == S_FILL);
    assign line_idx  = sec_start ? '0 : cnt_q;
    assign last_take = accept && (line_idx == LAST_IDX);

    ecc_parity_acc #(.LW(LINE_W), .BW(BIT_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (sec_start),
        .take     (accept),
        .line_idx (line_idx),
        .din      (byte_in),
        .par_now  (par_now)
    );

    assign code_now = ~par_now;

    ecc_syndrome_classify #(.SECTOR_BYTES(SECTOR_BYTES)) u_cls (
        .calc_code   (code_now),
        .stored_code (stored_code),
        .status      (cls_status),
        .byte_idx    (cls_byte),
        .bit_mask    (cls_mask)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (last_take)      state_d = S_DONE;
                else if (sec_start) state_d = S_FILL;
            end
            S_FILL: begin
                if (last_take)      state_d = S_DONE;
            end
            S_DONE: begin
                if (last_take)      state_d = S_DONE;
                else if (sec_start) state_d = S_FILL;
                else                state_d = S_IDLE;
            end
            default:                state_d = S_IDLE;
        endcase
    end

    // state register, byte counter and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            cnt_q      <= '0;
            calc_code  <= '0;
            ecc_status <= ST_CLEAN;
            err_byte   <= '0;
            err_mask   <= '0;
        end else begin
            state_q <= state_d;
            if (accept)         cnt_q <= line_idx + 1'b1;
            else if (sec_start) cnt_q <= '0;
            if (last_take) begin
                calc_code  <= code_now;
                ecc_status <= cls_status;
                err_byte   <= cls_byte;
                err_mask   <= cls_mask;
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        result_done = (state_q == S_DONE);
    end

    // R4
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_take |=> result_done);

    // R4
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !last_take |=> $stable(calc_code) && $stable(ecc_status) && $stable(err_mask));

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_FILL |-> int'(cnt_q) < SECTOR_BYTES);

    // R7
    clean_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_take |=> (ecc_status != ST_CLEAN) || (calc_code == $past(stored_code)));

    // R8
    fix_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_done && ecc_status == ST_FIXED |-> $countones(err_mask) == 1
                                               && int'(err_byte) < SECTOR_BYTES);

    // R10
    code_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_done && ecc_status != ST_FIXED |-> err_mask == '0 && err_byte == '0);
endmodule

// File: tb/sim_nand_hamm_ecc.sv
module sim_nand_hamm_ecc;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic s0 = 0, v0 = 0, s1 = 0, v1 = 0;
    logic [7:0]  d0 = 0, d1 = 0;
    logic [23:0] k0 = 0, k1 = 0;
    logic [23:0] code0, code1;
    logic [1:0]  st0, st1;
    logic [8:0]  eb0, eb1;
    logic [7:0]  em0, em1;
    logic        done0, done1;
    logic        exp0 = 0, exp1 = 0;

    int checks = 0;
    int fails  = 0;
    logic [7:0] mem [512];

    nand_hamm_ecc #(.SECTOR_BYTES(512)) u0 (
        .clk(clk), .rst_n(rst_n), .sec_start(s0), .byte_valid(v0), .byte_in(d0),
        .stored_code(k0), .calc_code(code0), .ecc_status(st0), .err_byte(eb0),
        .err_mask(em0), .result_done(done0));

    nand_hamm_ecc #(.SECTOR_BYTES(256)) u1 (
        .clk(clk), .rst_n(rst_n), .sec_start(s1), .byte_valid(v1), .byte_in(d1),
        .stored_code(k1), .calc_code(code1), .ecc_status(st1), .err_byte(eb1),
        .err_mask(em1), .result_done(done1));

    function automatic logic [23:0] ref_code(input int n);
        logic [11:0] lo = '0, hi = '0;
        for (int i = 0; i < n; i++) begin
            for (int j = 0; j < 8; j++) begin
                if (mem[i][j]) begin
                    int a = i * 8 + j;
                    for (int k = 0; k < 12; k++) begin
                        if (((a >> k) & 1) == 1) hi[k] = ~hi[k];
                        else                     lo[k] = ~lo[k];
                    end
                end
            end
        end
        return ~{hi, lo};
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        chk(done0 == exp0, "R4 done pulse u0", {31'b0, done0}, {31'b0, exp0});
        chk(done1 == exp1, "R4 done pulse u1", {31'b0, done1}, {31'b0, exp1});
    endtask

    task automatic drive(input int w, input logic s, input logic v, input logic [7:0] b,
                         input logic [23:0] st, input logic last);
        if (w == 0) begin
            s0 = s; v0 = v; d0 = b; k0 = st; s1 = 0; v1 = 0; exp0 = last; exp1 = 0;
        end else begin
            s1 = s; v1 = v; d1 = b; k1 = st; s0 = 0; v0 = 0; exp1 = last; exp0 = 0;
        end
        tick();
    endtask

    task automatic run(input int w, input int n, input logic [23:0] st, input int gap, input logic mark);
        for (int i = 0; i < n; i++) begin
            if (gap > 0 && (i % gap) == gap - 1) drive(w, 0, 0, 8'h5A, st, 0);
            drive(w, i == 0, 1, mem[i], st, mark && (i == n - 1));
        end
    endtask

    task automatic check_result(input int w, input logic [23:0] c, input logic [1:0] s,
                                input logic [8:0] b, input logic [7:0] m, input string tag);
        logic [23:0] ac = (w == 0) ? code0 : code1;
        logic [1:0]  as = (w == 0) ? st0 : st1;
        logic [8:0]  ab = (w == 0) ? eb0 : eb1;
        logic [7:0]  am = (w == 0) ? em0 : em1;
        chk(ac == c, {tag, " code"},   {8'b0, ac},  {8'b0, c});
        chk(as == s, {tag, " status"}, {30'b0, as}, {30'b0, s});
        chk(ab == b, {tag, " byte"},   {23'b0, ab}, {23'b0, b});
        chk(am == m, {tag, " mask"},   {24'b0, am}, {24'b0, m});
    endtask

    task automatic fill_random(input int n);
        for (int i = 0; i < n; i++) mem[i] = 8'($urandom);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=running exp=finished");
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

    initial begin
        logic [23:0] c, cf;
        int pb, pt, pb2, pt2, a;
        void'($urandom(32'h1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        check_result(0, 24'h0, 2'd0, 9'd0, 8'd0, "R1 reset");
        chk(done0 == 0, "R1 reset done", {31'b0, done0}, 0);
        rst_n = 1'b1;
        tick();
        check_result(0, 24'h0, 2'd0, 9'd0, 8'd0, "R1 after release");

        // R3 erased sector
        for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
        run(0, 512, 24'hFFFFFF, 0, 1);
        check_result(0, 24'hFFFFFF, 2'd0, 9'd0, 8'd0, "R3 erased");

        // R2 R7 clean random sectors, the second with idle gaps (R6)
        fill_random(512);
        c = ref_code(512);
        run(0, 512, c, 0, 1);
        check_result(0, c, 2'd0, 9'd0, 8'd0, "R2 R7 clean");
        fill_random(512);
        c = ref_code(512);
        run(0, 512, c, 7, 1);
        check_result(0, c, 2'd0, 9'd0, 8'd0, "R6 gaps clean");

        // R6 bytes with no open sector are ignored, outputs hold (R4)
        for (int i = 0; i < 5; i++) drive(0, 0, 1, 8'($urandom), 24'h0, 0);
        check_result(0, c, 2'd0, 9'd0, 8'd0, "R6 ignored idle bytes");
        run(0, 512, c, 0, 1);
        check_result(0, c, 2'd0, 9'd0, 8'd0, "R6 after ignored");

        // R8 single data-bit errors, corners then random positions
        for (int t = 0; t < 6; t++) begin
            fill_random(512);
            c = ref_code(512);
            if (t == 0)      begin pb = 0;   pt = 0; end
            else if (t == 1) begin pb = 511; pt = 7; end
            else             begin pb = $urandom_range(1, 510); pt = $urandom_range(0, 7); end
            mem[pb][pt] = ~mem[pb][pt];
            cf = ref_code(512);
            run(0, 512, c, (t == 3) ? 11 : 0, 1);
            check_result(0, cf, 2'd1, 9'(pb), 8'(1 << pt), "R8 data bit");
        end

        // R10 error in the stored code only
        for (int t = 0; t < 3; t++) begin
            fill_random(512);
            c = ref_code(512);
            a = (t == 0) ? 0 : (t == 1) ? 13 : 23;
            run(0, 512, c ^ (24'h1 << a), 0, 1);
            check_result(0, c, 2'd2, 9'd0, 8'd0, "R10 code bit");
        end

        // R11 double data-bit errors and a two-bit code error
        for (int t = 0; t < 2; t++) begin
            fill_random(512);
            c = ref_code(512);
            pb = $urandom_range(0, 255); pt = $urandom_range(0, 7);
            pb2 = $urandom_range(256, 511); pt2 = $urandom_range(0, 7);
            mem[pb][pt] = ~mem[pb][pt];
            mem[pb2][pt2] = ~mem[pb2][pt2];
            cf = ref_code(512);
            run(0, 512, c, 0, 1);
            check_result(0, cf, 2'd3, 9'd0, 8'd0, "R11 double data");
        end
        fill_random(512);
        c = ref_code(512);
        run(0, 512, c ^ 24'h000003, 0, 1);
        check_result(0, c, 2'd3, 9'd0, 8'd0, "R11 two code bits");

        // R5 restart after a partial sector
        fill_random(512);
        run(0, 100, 24'h0, 0, 0);
        fill_random(512);
        c = ref_code(512);
        run(0, 512, c, 0, 1);
        check_result(0, c, 2'd0, 9'd0, 8'd0, "R5 restart");

        // R8 and R9 on the 256-byte instance
        fill_random(256);
        c = ref_code(256);
        a = 10 * 8 + 2;
        run(1, 256, c ^ {12'(a), ~12'(a)}, 0, 1);
        check_result(1, c, 2'd1, 9'd10, 8'h04, "R8 short sector");
        fill_random(256);
        c = ref_code(256);
        a = 300 * 8 + 5;
        run(1, 256, c ^ {12'(a), ~12'(a)}, 0, 1);
        check_result(1, c, 2'd3, 9'd0, 8'd0, "R9 byte out of range");

        drive(0, 0, 0, 8'h00, 24'h0, 0);
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end
endmodule